// File: doc/BRIEF.md
# Bit-Band Alias Access Translator

This block sits on the path from a bus master to its memory and peripheral targets. It turns accesses to single-bit alias words into real bit operations. Two alias windows are decoded. Each alias window is 32 times the size of a matching bit-band region, and each alias word stands for one bit of one byte in that region. Reading an alias word returns the addressed bit. Writing an alias word sets or clears that bit alone: the block reads the word that holds the bit, changes the bit, and writes the word back.

Any address outside both alias windows is forwarded downstream unchanged, as a single transaction, and its response comes back untouched. Both sides of the block use the same simple handshake. A request channel carries valid/ready, address, write enable and write data. A response channel carries valid/ready, read data and an error flag. The block serves one upstream request at a time. It accepts no new request until the response to the current one has been taken. This keeps a bit update atomic with respect to this master.

Top module: `bitalias_xlate`

## Requirements
- R1: An address from 0x22000000 to 0x23FFFFFF is an alias of the band 0x20000000..0x200FFFFF. The byte address is the band base plus alias bits [24:5], and the bit within that byte is alias bits [4:2]. Every downstream access made for an alias is word aligned and falls inside the band.
- R2: An alias write makes exactly two downstream transactions: a read of the containing word, then a write of that word with only the selected bit changed. The selected bit is at position 8 × (byte address mod 4) + bit-in-byte (little-endian lanes). The upstream write response carries read data 0.
- R3: For an alias write, the new value of the target bit is bit 0 of the write data. Write data bits [31:1] have no effect.
- R4: An alias read makes one downstream read of the containing word. It returns the selected bit in bit 0 of the response, with bits [31:1] zero.
- R5: An access outside both alias windows, including addresses next to their edges, is forwarded with the same address, write enable and write data in one downstream transaction. Its read data and error are returned unchanged. A request or response that is not yet accepted holds its values.
- R6: The second alias window, 0x42000000 to 0x43FFFFFF, maps to the band 0x40000000..0x400FFFFF with the same rule as R1.
- R7: From the acceptance of an upstream request until its response is taken, up_req_ready stays low.
- R8: If the downstream read step of an alias write returns an error, no downstream write is issued and the upstream response carries the error. Errors on alias reads and on forwarded accesses are also returned upstream.
- R9: After reset, up_req_ready is high and dn_req_valid and up_rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted |
| up_req_addr | input | ADDR_W | Upstream byte address |
| up_req_we | input | 1 | Upstream write enable |
| up_req_wdata | input | DATA_W | Upstream write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response taken |
| up_rsp_rdata | output | DATA_W | Upstream response read data |
| up_rsp_err | output | 1 | Upstream response error |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_addr | output | ADDR_W | Downstream byte address |
| dn_req_we | output | 1 | Downstream write enable |
| dn_req_wdata | output | DATA_W | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Downstream response taken |
| dn_rsp_rdata | input | DATA_W | Downstream response read data |
| dn_rsp_err | input | 1 | Downstream response error |

## Verification
The bench targets the top alias word of a window. That word maps to the highest bit of the last byte of the band. A decoder that dropped an offset bit, or numbered byte lanes big-endian, would change the wrong bit of that word. It clears a bit using write data whose upper bits are all ones, and sets a bit in a word that already holds other ones. A design that stored the whole data word, or that did not merge the bit into the word it read, would corrupt the neighbours. It sends addresses just below and just above a window, and a decoder with a loose compare would translate those. It also forces an error on the read step and counts downstream writes, because a design that kept going after an error would write a stale word.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;

    // Sequencer phase of the translator.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DN_REQ,
        ST_DN_RSP,
        ST_UP_RSP
    } xl_state_e;

    // What the accepted upstream request turned into.
    typedef enum logic [1:0] {
        KIND_PASS,
        KIND_BIT_RD,
        KIND_BIT_WR
    } xl_kind_e;

endpackage

// File: rtl/bitalias_win_match.sv
// One alias window: hit detection and byte address rebuild.
module bitalias_win_match #(
    parameter int unsigned          ADDR_W     = 32,
    parameter int unsigned          BAND_BITS  = 20,
    parameter logic [ADDR_W-1:0]    BAND_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0]    ALIAS_BASE = 32'h2200_0000
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] byte_addr_o
);
    // One alias word per bit: window is 32x the band, so 5 more bits.
    localparam int unsigned TAG_LSB = BAND_BITS + 5;

    logic [ADDR_W-1:0] offset;
    logic              unused_lo;

    assign hit_o       = (addr_i[ADDR_W-1:TAG_LSB] == ALIAS_BASE[ADDR_W-1:TAG_LSB]);
    assign offset      = {{(ADDR_W-BAND_BITS){1'b0}}, addr_i[TAG_LSB-1:5]};
    assign byte_addr_o = BAND_BASE + offset;
    assign unused_lo   = ^addr_i[4:0];
endmodule

// File: rtl/bitalias_decode.sv
// Combines all alias windows into one decode result.
module bitalias_decode #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BAND_BITS = 20,
    parameter int unsigned NUM_WIN   = 2,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] BAND_BASE  = {32'h4000_0000, 32'h2000_0000},
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
    localparam int unsigned LANE_W = $clog2(DATA_W/8),
    localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              is_alias_o,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic [IDX_W-1:0]  bit_idx_o
);
    logic [NUM_WIN-1:0]             hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0] byte_addr;
    logic [ADDR_W-1:0]              sel_byte;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        bitalias_win_match #(
            .ADDR_W     (ADDR_W),
            .BAND_BITS  (BAND_BITS),
            .BAND_BASE  (BAND_BASE[g]),
            .ALIAS_BASE (ALIAS_BASE[g])
        ) i_win (
            .addr_i      (addr_i),
            .hit_o       (hit[g]),
            .byte_addr_o (byte_addr[g])
        );
    end

    always_comb begin
        is_alias_o = 1'b0;
        sel_byte   = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit[i]) begin
                is_alias_o = 1'b1;
                sel_byte   = byte_addr[i];
            end
        end
    end

    // Little-endian: byte lane selects the group of 8 bits in the word.
    assign word_addr_o = {sel_byte[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    assign bit_idx_o   = {sel_byte[LANE_W-1:0], addr_i[4:2]};
endmodule

// File: rtl/bitalias_bit_ops.sv
// Single-bit extraction and insertion on a data word.
module bitalias_bit_ops #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] zext_bit_o,
    output logic [DATA_W-1:0] word_o
);
    always_comb begin
        zext_bit_o    = '0;
        zext_bit_o[0] = word_i[idx_i];
        word_o        = word_i;
        word_o[idx_i] = bit_i;
    end
endmodule

// File: rtl/bitalias_xlate.sv
module bitalias_xlate
    import bitalias_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BAND_BITS = 20,
    parameter int unsigned NUM_WIN   = 2,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] BAND_BASE  = {32'h4000_0000, 32'h2000_0000},
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req_valid,
    output logic              up_req_ready,
    input  logic [ADDR_W-1:0] up_req_addr,
    input  logic              up_req_we,
    input  logic [DATA_W-1:0] up_req_wdata,
    output logic              up_rsp_valid,
    input  logic              up_rsp_ready,
    output logic [DATA_W-1:0] up_rsp_rdata,
    output logic              up_rsp_err,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic [ADDR_W-1:0] dn_req_addr,
    output logic              dn_req_we,
    output logic [DATA_W-1:0] dn_req_wdata,
    input  logic              dn_rsp_valid,
    output logic              dn_rsp_ready,
    input  logic [DATA_W-1:0] dn_rsp_rdata,
    input  logic              dn_rsp_err
);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    typedef struct packed {
        xl_state_e         st;
        xl_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [IDX_W-1:0]  bit_idx;
        logic              new_bit;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } xl_regs_t;

    xl_regs_t r_d, r_q;

    logic              dec_alias;
    logic [ADDR_W-1:0] dec_word_addr;
    logic [IDX_W-1:0]  dec_bit_idx;
    logic [DATA_W-1:0] rd_bit_word;
    logic [DATA_W-1:0] merged_word;

    bitalias_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .BAND_BITS  (BAND_BITS),
        .NUM_WIN    (NUM_WIN),
        .BAND_BASE  (BAND_BASE),
        .ALIAS_BASE (ALIAS_BASE)
    ) i_decode (
        .addr_i      (up_req_addr),
        .is_alias_o  (dec_alias),
        .word_addr_o (dec_word_addr),
        .bit_idx_o   (dec_bit_idx)
    );

    bitalias_bit_ops #(
        .DATA_W (DATA_W)
    ) i_bit_ops (
        .word_i     (dn_rsp_rdata),
        .idx_i      (r_q.bit_idx),
        .bit_i      (r_q.new_bit),
        .zext_bit_o (rd_bit_word),
        .word_o     (merged_word)
    );

    always_comb begin
        r_d = r_q;

        up_req_ready = 1'b0;
        dn_req_valid = 1'b0;
        dn_rsp_ready = 1'b0;
        up_rsp_valid = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                up_req_ready = 1'b1;
                if (up_req_valid) begin
                    r_d.st      = ST_DN_REQ;
                    r_d.wdata   = up_req_wdata;
                    r_d.new_bit = up_req_wdata[0];
                    r_d.bit_idx = dec_bit_idx;
                    r_d.rdata   = '0;
                    r_d.err     = 1'b0;
                    if (dec_alias) begin
                        r_d.kind = up_req_we ? KIND_BIT_WR : KIND_BIT_RD;
                        r_d.addr = dec_word_addr;
                        r_d.we   = 1'b0;  // both alias kinds start with a read
                    end else begin
                        r_d.kind = KIND_PASS;
                        r_d.addr = up_req_addr;
                        r_d.we   = up_req_we;
                    end
                end
            end

            ST_DN_REQ: begin
                dn_req_valid = 1'b1;
                if (dn_req_ready) begin
                    r_d.st = ST_DN_RSP;
                end
            end

            ST_DN_RSP: begin
                dn_rsp_ready = 1'b1;
                if (dn_rsp_valid) begin
                    r_d.st  = ST_UP_RSP;
                    r_d.err = dn_rsp_err;
                    unique case (r_q.kind)
                        KIND_PASS: begin
                            r_d.rdata = dn_rsp_rdata;
                        end
                        KIND_BIT_RD: begin
                            r_d.rdata = dn_rsp_err ? '0 : rd_bit_word;
                        end
                        default: begin
                            r_d.rdata = '0;
                            if (!r_q.we && !dn_rsp_err) begin
                                // read step done: write the merged word back
                                r_d.st    = ST_DN_REQ;
                                r_d.we    = 1'b1;
                                r_d.wdata = merged_word;
                            end
                        end
                    endcase
                end
            end

            ST_UP_RSP: begin
                up_rsp_valid = 1'b1;
                if (up_rsp_ready) begin
                    r_d.st = ST_IDLE;
                end
            end

            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.kind    <= KIND_PASS;
            r_q.addr    <= '0;
            r_q.we      <= 1'b0;
            r_q.wdata   <= '0;
            r_q.bit_idx <= '0;
            r_q.new_bit <= 1'b0;
            r_q.rdata   <= '0;
            r_q.err     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dn_req_addr  = r_q.addr;
    assign dn_req_we    = r_q.we;
    assign dn_req_wdata = r_q.wdata;
    assign up_rsp_rdata = r_q.rdata;
    assign up_rsp_err   = r_q.err;
endmodule

// File: rtl/bitalias_xlate_chk.sv
module bitalias_xlate_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_req_valid,
    input logic              up_req_ready,
    input logic [ADDR_W-1:0] up_req_addr,
    input logic              up_req_we,
    input logic              up_rsp_valid,
    input logic              up_rsp_ready,
    input logic [DATA_W-1:0] up_rsp_rdata,
    input logic              dn_req_valid,
    input logic              dn_req_ready,
    input logic [ADDR_W-1:0] dn_req_addr,
    input logic              dn_req_we,
    input logic [DATA_W-1:0] dn_req_wdata,
    input logic              dn_rsp_valid,
    input logic              dn_rsp_ready,
    input logic              dn_rsp_err
);
    logic req_alias;
    logic alias_q, alias_rd_q, err_q;

    assign req_alias = (up_req_addr[ADDR_W-1:25] == 7'h11) ||
                       (up_req_addr[ADDR_W-1:25] == 7'h21);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alias_q    <= 1'b0;
            alias_rd_q <= 1'b0;
            err_q      <= 1'b0;
        end else if (up_req_valid && up_req_ready) begin
            alias_q    <= req_alias;
            alias_rd_q <= req_alias && !up_req_we;
            err_q      <= 1'b0;
        end else if (dn_rsp_valid && dn_rsp_ready && dn_rsp_err && alias_q) begin
            err_q      <= 1'b1;
        end
    end

    AST_RSP_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid |-> !up_req_ready); // R7

    AST_DN_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> !up_req_ready); // R7

    AST_DN_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr)
            && $stable(dn_req_we) && $stable(dn_req_wdata)); // R5

    AST_UP_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid && !up_rsp_ready |=> up_rsp_valid && $stable(up_rsp_rdata)); // R5

    AST_ALIAS_RD_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid && alias_rd_q |-> up_rsp_rdata[DATA_W-1:1] == '0); // R4

    AST_ALIAS_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && alias_q |-> dn_req_addr[1:0] == 2'b00); // R1

    AST_ALIAS_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && alias_q |-> (dn_req_addr[ADDR_W-1:20] == 12'h200)
                                 || (dn_req_addr[ADDR_W-1:20] == 12'h400)); // R6

    AST_NO_WR_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !(dn_req_valid && dn_req_we)); // R8
endmodule

bind bitalias_xlate bitalias_xlate_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (.*);

// File: tb/test_bitalias_xlate.sv
`timescale 1ns/1ps
module test_bitalias_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req_valid = 1'b0;
    logic        up_req_ready;
    logic [31:0] up_req_addr = '0;
    logic        up_req_we = 1'b0;
    logic [31:0] up_req_wdata = '0;
    logic        up_rsp_valid;
    logic        up_rsp_ready = 1'b1;
    logic [31:0] up_rsp_rdata;
    logic        up_rsp_err;
    logic        dn_req_valid;
    logic        dn_req_ready;
    logic [31:0] dn_req_addr;
    logic        dn_req_we;
    logic [31:0] dn_req_wdata;
    logic        dn_rsp_valid;
    logic        dn_rsp_ready;
    logic [31:0] dn_rsp_rdata;
    logic        dn_rsp_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int n_dn = 0;
    int n_dn_wr = 0;

    always #4 clk = ~clk;

    bitalias_xlate i_bitalias_xlate (.*);

    // Downstream memory model: one outstanding transaction.
    localparam logic [31:0] ERR_ADDR = 32'h2000_00F0;
    logic [31:0] mem [logic [31:0]];
    logic        pend = 1'b0;
    logic [31:0] p_rdata = '0;
    logic        p_err = 1'b0;

    assign dn_req_ready = !pend;
    assign dn_rsp_valid = pend;
    assign dn_rsp_rdata = p_rdata;
    assign dn_rsp_err   = p_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            if (pend && dn_rsp_ready) pend <= 1'b0;
            if (dn_req_valid && !pend) begin
                pend <= 1'b1;
                n_dn = n_dn + 1;
                if (dn_req_addr == ERR_ADDR) begin
                    p_err   <= 1'b1;
                    p_rdata <= '0;
                end else begin
                    p_err <= 1'b0;
                    if (dn_req_we) begin
                        n_dn_wr = n_dn_wr + 1;
                        mem[dn_req_addr] = dn_req_wdata;
                        p_rdata <= '0;
                    end else begin
                        p_rdata <= mem.exists(dn_req_addr) ? mem[dn_req_addr] : 32'h0;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d,
                          output logic [31:0] r, output logic e);
        @(negedge clk);
        up_req_valid = 1'b1;
        up_req_addr  = a;
        up_req_we    = w;
        up_req_wdata = d;
        while (!up_req_ready) @(negedge clk);
        @(negedge clk);
        up_req_valid = 1'b0;
        while (!up_rsp_valid) @(negedge clk);
        r = up_rsp_rdata;
        e = up_rsp_err;
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic        we;
        logic [31:0] wdata;
        logic [31:0] exp_rdata;
        logic        exp_err;
        logic [1:0]  exp_dn;
        logic [1:0]  exp_wr;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VEC [NVEC] = '{
        '{32'h2000_0010, 1'b1, 32'hA5A5_0F0F, 32'h0,         1'b0, 2'd1, 2'd1, 4'd5}, // R5 forwarded write
        '{32'h2000_0010, 1'b0, 32'h0,         32'hA5A5_0F0F, 1'b0, 2'd1, 2'd0, 4'd5}, // R5 forwarded read
        '{32'h2200_001C, 1'b1, 32'h0000_0001, 32'h0,         1'b0, 2'd2, 2'd1, 4'd2}, // R1 R2 byte 0 bit 7
        '{32'h2000_0000, 1'b0, 32'h0,         32'h0000_0180, 1'b0, 2'd1, 2'd0, 4'd2}, // R2 neighbour bit kept
        '{32'h23FF_FFFC, 1'b1, 32'hFFFF_FFFE, 32'h0,         1'b0, 2'd2, 2'd1, 4'd3}, // R3 top alias word, clear
        '{32'h200F_FFFC, 1'b0, 32'h0,         32'h7FFF_FFFF, 1'b0, 2'd1, 2'd0, 4'd3}, // R3 only bit 31 cleared
        '{32'h23FF_FFF8, 1'b0, 32'h0,         32'h0000_0001, 1'b0, 2'd1, 2'd0, 4'd4}, // R4 bit 30 reads 1
        '{32'h23FF_FFFC, 1'b0, 32'h0,         32'h0000_0000, 1'b0, 2'd1, 2'd0, 4'd4}, // R4 bit 31 reads 0
        '{32'h4200_020C, 1'b1, 32'h0000_0003, 32'h0,         1'b0, 2'd2, 2'd1, 4'd6}, // R6 byte 0x10 bit 3
        '{32'h4200_0200, 1'b1, 32'hFFFF_FFFF, 32'h0,         1'b0, 2'd2, 2'd1, 4'd6}, // R6 byte 0x10 bit 0
        '{32'h4000_0010, 1'b0, 32'h0,         32'h0000_0009, 1'b0, 2'd1, 2'd0, 4'd6}, // R6 result word
        '{32'h4200_020C, 1'b0, 32'h0,         32'h0000_0001, 1'b0, 2'd1, 2'd0, 4'd4}, // R4 second window read
        '{32'h2200_0240, 1'b1, 32'hFFFF_FFFE, 32'h0,         1'b0, 2'd2, 2'd1, 4'd2}, // R2 lane 2 bit 0
        '{32'h2000_0010, 1'b0, 32'h0,         32'hA5A4_0F0F, 1'b0, 2'd1, 2'd0, 4'd2}, // R2 bit 16 cleared
        '{32'h21FF_FFFC, 1'b0, 32'h0,         32'hCAFE_F00D, 1'b0, 2'd1, 2'd0, 4'd5}, // R5 below window
        '{32'h2400_0000, 1'b0, 32'h0,         32'h1234_5678, 1'b0, 2'd1, 2'd0, 4'd5}, // R5 above window
        '{32'h2200_1E00, 1'b1, 32'h0000_0001, 32'h0,         1'b1, 2'd1, 2'd0, 4'd8}, // R8 error stops write
        '{32'h2200_1E04, 1'b0, 32'h0,         32'h0,         1'b1, 2'd1, 2'd0, 4'd8}, // R8 alias read error
        '{32'h2000_00F0, 1'b0, 32'h0,         32'h0,         1'b1, 2'd1, 2'd0, 4'd8}  // R8 forwarded error
    };

    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic        e;
        logic        rdy_seen;
        logic [31:0] held;

        mem[32'h2000_0000] = 32'h0000_0100;
        mem[32'h200F_FFFC] = 32'hFFFF_FFFF;
        mem[32'h21FF_FFFC] = 32'hCAFE_F00D;
        mem[32'h2400_0000] = 32'h1234_5678;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 up_req_ready", {31'b0, up_req_ready}, 32'h1);
        chk("R9 dn_req_valid", {31'b0, dn_req_valid}, 32'h0);
        chk("R9 up_rsp_valid", {31'b0, up_rsp_valid}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            int dn0;
            int wr0;
            string tag;
            dn0 = n_dn;
            wr0 = n_dn_wr;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            access(VEC[i].addr, VEC[i].we, VEC[i].wdata, r, e);
            chk({tag, " rdata"}, r, VEC[i].exp_rdata);
            chk({tag, " err"}, {31'b0, e}, {31'b0, VEC[i].exp_err});
            chk({tag, " dn count"}, n_dn - dn0, {30'b0, VEC[i].exp_dn});
            chk({tag, " dn writes"}, n_dn_wr - wr0, {30'b0, VEC[i].exp_wr});
        end

        // R7: ready stays low through a whole read-modify-write
        @(negedge clk);
        up_req_valid = 1'b1;
        up_req_addr  = 32'h2200_0000;
        up_req_we    = 1'b1;
        up_req_wdata = 32'h1;
        while (!up_req_ready) @(negedge clk);
        @(negedge clk);
        rdy_seen = 1'b0;
        while (!up_rsp_valid) begin
            if (up_req_ready) rdy_seen = 1'b1;
            @(negedge clk);
        end
        if (up_req_ready) rdy_seen = 1'b1;
        up_req_valid = 1'b0;
        chk("R7 ready during sequence", {31'b0, rdy_seen}, 32'h0);
        @(negedge clk);
        chk("R7 ready after response", {31'b0, up_req_ready}, 32'h1);

        // R5: response held under upstream back-pressure
        up_rsp_ready = 1'b0;
        access(32'h2400_0000, 1'b0, 32'h0, r, e);
        held = r;
        repeat (3) @(negedge clk);
        chk("R5 held valid", {31'b0, up_rsp_valid}, 32'h1);
        chk("R5 held data", up_rsp_rdata, held);
        chk("R5 held data value", held, 32'h1234_5678);
        up_rsp_ready = 1'b1;
        @(negedge clk);
        chk("R5 released", {31'b0, up_rsp_valid}, 32'h0);

        // R1: word written by the R7 sequence holds bit 0 set
        access(32'h2000_0000, 1'b0, 32'h0, r, e);
        chk("R1 byte 0 bit 0", r, 32'h0000_0181);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule